// File: doc/BRIEF.md
# Compressed-Row Sparse Product Stream Generator

This block walks a sparse matrix held in compressed-row form and turns it into a stream of tagged products, one for each nonzero. Three inputs describe the matrix. An element stream carries each nonzero's value together with its column index. A pointer stream carries, for every row, the running element index at which that row starts, plus one final pointer that closes the last row. For each element the block reads the dense-vector entry at the element's column from an on-chip vector memory and multiplies it by the element value. It then emits the product with the row number it belongs to and flags that mark the first and last record of that row, so a downstream reducer can clear and close its accumulator.

A host fills the vector memory through a write port while the block is idle. It then sets the row count and pulses `start`. The walker is a state machine. `IDLE` waits for start and goes to `BASE` on the pulse. `BASE` takes the first pointer as the origin of the element index, then moves to `BOUND`, or to `DRAIN` when the row count is zero. `BOUND` takes the next pointer as the end of the current row and picks `STREAM` when the row holds elements or `EMPTY` when it holds none. `STREAM` accepts one element per cycle until the index reaches the row end, then returns to `BOUND` for the next row, or moves to `DRAIN` after the last row. `EMPTY` issues one zero record and then moves to `BOUND` or `DRAIN` on the same terms. `DRAIN` waits until the two pipeline registers are empty and then moves to `DONE`. `DONE` holds the done flag until the next start, which goes back to `BASE`.

Top module: `csr_prod_stream`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `done`, `el_ready` and `ptr_ready` are all low.
- R2: Each record's `out_prod` equals the unsigned product of the element value and the vector-memory word at address `el_col`. That word is whatever the write port stored there: a write with `vec_wr_en` high at a clock edge sets that address.
- R3: Records carry `out_row` values 0 up to `num_rows`-1 in ascending order. Row r receives ptr[r+1] minus ptr[r] records, where ptr[0] is the first pointer of the run and sets the origin of the element index, which need not be zero.
- R4: `out_first` is 1 exactly on the first record of a row and `out_last` is 1 exactly on its final record. A row's first record always follows the previous row's last record.
- R5: A row whose closing pointer equals its opening pointer yields exactly one record, with `out_prod` 0 and both `out_first` and `out_last` set, and consumes no element.
- R6: While `out_valid` is high and `out_ready` is low, every output field holds its value at the next edge.
- R7: `el_ready` is low in every cycle in which the output register is stalled (`out_valid` high, `out_ready` low).
- R8: `done` rises only after the last record of the run has been transferred. It stays high with `out_valid` low until the next `start`.
- R9: With no output backpressure, the record for an element accepted at edge k is valid at the output after edge k+1.
- R10: A `start` pulse while a run is in progress has no effect on the records or on which inputs are consumed.
- R11: With `num_rows` of zero, a run consumes one pointer, accepts no element, emits no record and then raises `done`.
- R12: `el_ready` and `ptr_ready` are never high together. A run consumes exactly `num_rows`+1 pointers and as many elements as the pointers span.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_wr_en | input | 1 | Vector memory write strobe |
| vec_wr_addr | input | ADDR_W | Vector memory write address |
| vec_wr_data | input | DATA_W | Vector memory write data |
| start | input | 1 | Begin a run (sampled in IDLE or DONE) |
| num_rows | input | ROW_W | Number of rows in the run, latched at start |
| done | output | 1 | Run finished and output drained |
| ptr_valid | input | 1 | Row pointer available |
| ptr_ready | output | 1 | Row pointer taken this cycle |
| ptr_data | input | IDX_W | Row pointer value (running element index) |
| el_valid | input | 1 | Element available |
| el_ready | output | 1 | Element taken this cycle |
| el_val | input | DATA_W | Element value |
| el_col | input | ADDR_W | Element column (vector memory address) |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Downstream accepts record |
| out_prod | output | 2*DATA_W | Product value |
| out_row | output | ROW_W | Row the record belongs to |
| out_first | output | 1 | First record of its row |
| out_last | output | 1 | Last record of its row |

## Verification
The hardest situation to reach is the output register stalling just as a row boundary or an empty row is being issued. In that case the walker must hold its state, the element index and the first-of-row flag across several frozen cycles without emitting a duplicate or losing a zero record. Matrices with runs of empty rows, including a trailing empty row, are fed while `out_ready` drops at random and the input streams have random gaps. This makes stalls land on every walker state. A behavioural queue model built from the pointers predicts each record and is checked on every clock, together with hold-under-stall.

// File: rtl/csr_pkg.sv
package csr_pkg;

    // Walker states; encoding carries no meaning outside the walker.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE,
        ST_BOUND,
        ST_STREAM,
        ST_EMPTY,
        ST_DRAIN,
        ST_DONE
    } walk_state_e;

    // True when a row closing pointer leaves the row without elements.
    function automatic logic row_is_empty(input logic [31:0] open_idx,
                                          input logic [31:0] close_idx);
        return (close_idx <= open_idx);
    endfunction

endpackage

// File: rtl/csr_vec_mem.sv
module csr_vec_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    parameter bit REG_RD = 1'b1,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // One cycle of read latency; the word holds until the next read.
    generate
        if (REG_RD) begin : g_rd_reg
            logic [DATA_W-1:0] rd_q;
            always_ff @(posedge clk) begin
                if (rd_en) begin
                    rd_q <= store[rd_addr];
                end
            end
            assign rd_data = rd_q;
        end else begin : g_rd_addr_reg
            logic [ADDR_W-1:0] addr_q;
            always_ff @(posedge clk) begin
                if (rd_en) begin
                    addr_q <= rd_addr;
                end
            end
            assign rd_data = store[addr_q];
        end
    endgenerate

endmodule

// File: rtl/csr_row_walker.sv
module csr_row_walker
    import csr_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] num_rows,
    input  logic             ptr_valid,
    output logic             ptr_ready,
    input  logic [IDX_W-1:0] ptr_data,
    input  logic             el_valid,
    output logic             el_ready,
    input  logic             adv,
    input  logic             pipe_empty,
    output logic             issue,
    output logic             issue_zero,
    output logic [ROW_W-1:0] issue_row,
    output logic             issue_first,
    output logic             issue_last,
    output logic             done
);

    walk_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] row_end_q;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] rows_q;
    logic             first_pend_q;

    logic             ptr_fire;
    logic             el_fire;
    logic             at_last_row;
    logic             elem_is_last;
    logic             bound_empty;

    assign ptr_fire     = ptr_valid && ptr_ready;
    assign el_fire      = el_valid && el_ready;
    assign at_last_row  = (row_q == rows_q - ROW_W'(1));
    assign elem_is_last = ((idx_q + IDX_W'(1)) == row_end_q);
    assign bound_empty  = row_is_empty(32'(idx_q), 32'(ptr_data));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_BASE;
            end
            ST_BASE: begin
                if (ptr_fire) begin
                    state_d = (rows_q == '0) ? ST_DRAIN : ST_BOUND;
                end
            end
            ST_BOUND: begin
                if (ptr_fire) begin
                    state_d = bound_empty ? ST_EMPTY : ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (el_fire && elem_is_last) begin
                    state_d = at_last_row ? ST_DRAIN : ST_BOUND;
                end
            end
            ST_EMPTY: begin
                if (adv) begin
                    state_d = at_last_row ? ST_DRAIN : ST_BOUND;
                end
            end
            ST_DRAIN: begin
                if (pipe_empty) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (start) state_d = ST_BASE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        ptr_ready   = 1'b0;
        el_ready    = 1'b0;
        issue       = 1'b0;
        issue_zero  = 1'b0;
        issue_first = first_pend_q;
        issue_last  = elem_is_last;
        done        = 1'b0;
        unique case (state_q)
            ST_BASE, ST_BOUND: ptr_ready = 1'b1;
            ST_STREAM: begin
                el_ready = adv;
                issue    = el_valid && adv;
            end
            ST_EMPTY: begin
                issue       = adv;
                issue_zero  = 1'b1;
                issue_first = 1'b1;
                issue_last  = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign issue_row = row_q;

    // Walk counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q        <= '0;
            row_end_q    <= '0;
            row_q        <= '0;
            rows_q       <= '0;
            first_pend_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        rows_q <= num_rows;
                        row_q  <= '0;
                    end
                end
                ST_BASE: begin
                    if (ptr_fire) idx_q <= ptr_data;
                end
                ST_BOUND: begin
                    if (ptr_fire) begin
                        row_end_q    <= ptr_data;
                        first_pend_q <= 1'b1;
                    end
                end
                ST_STREAM: begin
                    if (el_fire) begin
                        idx_q        <= idx_q + IDX_W'(1);
                        first_pend_q <= 1'b0;
                        if (elem_is_last && !at_last_row) begin
                            row_q <= row_q + ROW_W'(1);
                        end
                    end
                end
                ST_EMPTY: begin
                    if (adv && !at_last_row) begin
                        row_q <= row_q + ROW_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R7: no element is taken while the output register is stalled
    p_no_accept_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |-> !el_ready);

    // R12: the two input streams are never offered a handshake together
    p_ready_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(el_ready && ptr_ready));

endmodule

// File: rtl/csr_prod_pipe.sv
module csr_prod_pipe #(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 16,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_zero,
    input  logic [DATA_W-1:0] issue_val,
    input  logic [ROW_W-1:0]  issue_row,
    input  logic              issue_first,
    input  logic              issue_last,
    input  logic [DATA_W-1:0] vec_word,
    output logic              adv,
    output logic              pipe_empty,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PROD_W-1:0] out_prod,
    output logic [ROW_W-1:0]  out_row,
    output logic              out_first,
    output logic              out_last
);

    // Stage 1: waits for the vector word
    logic              s1_valid;
    logic              s1_zero;
    logic [DATA_W-1:0] s1_val;
    logic [ROW_W-1:0]  s1_row;
    logic              s1_first;
    logic              s1_last;
    logic [PROD_W-1:0] s1_prod;

    assign adv        = !(out_valid && !out_ready);
    assign pipe_empty = !s1_valid && !out_valid;
    assign s1_prod    = s1_zero ? '0 : (PROD_W'(s1_val) * PROD_W'(vec_word));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_zero  <= 1'b0;
            s1_val   <= '0;
            s1_row   <= '0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
        end else if (adv) begin
            s1_valid <= issue;
            if (issue) begin
                s1_zero  <= issue_zero;
                s1_val   <= issue_val;
                s1_row   <= issue_row;
                s1_first <= issue_first;
                s1_last  <= issue_last;
            end
        end
    end

    // Stage 2: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
            out_row   <= '0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
        end else if (adv) begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_prod  <= s1_prod;
                out_row   <= s1_row;
                out_first <= s1_first;
                out_last  <= s1_last;
            end
        end
    end

    // R6: a stalled record holds every field
    p_hold_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_prod) &&
            $stable(out_row) && $stable(out_first) && $stable(out_last)));

    // R4: a row opens only after the previous transfer closed a row
    logic prev_last_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_last_q <= 1'b1;
        end else if (out_valid && out_ready) begin
            prev_last_q <= out_last;
        end
    end

    p_first_follows_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (out_first == prev_last_q));

endmodule

// File: rtl/csr_prod_stream.sv
module csr_prod_stream #(
    parameter int DATA_W    = 32,
    parameter int VEC_DEPTH = 1024,
    parameter int IDX_W     = 16,
    parameter int ROW_W     = 16,
    localparam int ADDR_W   = $clog2(VEC_DEPTH),
    localparam int PROD_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_wr_en,
    input  logic [ADDR_W-1:0] vec_wr_addr,
    input  logic [DATA_W-1:0] vec_wr_data,
    input  logic              start,
    input  logic [ROW_W-1:0]  num_rows,
    output logic              done,
    input  logic              ptr_valid,
    output logic              ptr_ready,
    input  logic [IDX_W-1:0]  ptr_data,
    input  logic              el_valid,
    output logic              el_ready,
    input  logic [DATA_W-1:0] el_val,
    input  logic [ADDR_W-1:0] el_col,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PROD_W-1:0] out_prod,
    output logic [ROW_W-1:0]  out_row,
    output logic              out_first,
    output logic              out_last
);

    logic              adv;
    logic              pipe_empty;
    logic              issue;
    logic              issue_zero;
    logic [ROW_W-1:0]  issue_row;
    logic              issue_first;
    logic              issue_last;
    logic [DATA_W-1:0] vec_word;

    csr_row_walker #(
        .IDX_W (IDX_W),
        .ROW_W (ROW_W)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .num_rows    (num_rows),
        .ptr_valid   (ptr_valid),
        .ptr_ready   (ptr_ready),
        .ptr_data    (ptr_data),
        .el_valid    (el_valid),
        .el_ready    (el_ready),
        .adv         (adv),
        .pipe_empty  (pipe_empty),
        .issue       (issue),
        .issue_zero  (issue_zero),
        .issue_row   (issue_row),
        .issue_first (issue_first),
        .issue_last  (issue_last),
        .done        (done)
    );

    csr_vec_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (VEC_DEPTH),
        .REG_RD (1'b1)
    ) u_vec (
        .clk     (clk),
        .wr_en   (vec_wr_en),
        .wr_addr (vec_wr_addr),
        .wr_data (vec_wr_data),
        .rd_en   (issue && !issue_zero),
        .rd_addr (el_col),
        .rd_data (vec_word)
    );

    csr_prod_pipe #(
        .DATA_W (DATA_W),
        .ROW_W  (ROW_W)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .issue_zero  (issue_zero),
        .issue_val   (el_val),
        .issue_row   (issue_row),
        .issue_first (issue_first),
        .issue_last  (issue_last),
        .vec_word    (vec_word),
        .adv         (adv),
        .pipe_empty  (pipe_empty),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_prod    (out_prod),
        .out_row     (out_row),
        .out_first   (out_first),
        .out_last    (out_last)
    );

    // R8: done is never raised while a record is still presented
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

endmodule

// File: tb/csr_prod_stream_tb.sv
`timescale 1ns/1ps
module csr_prod_stream_tb;

    localparam int DW = 32;
    localparam int VD = 1024;
    localparam int AW = 10;
    localparam int IW = 16;
    localparam int RW = 16;
    localparam int PW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vec_wr_en = 1'b0;
    logic [AW-1:0] vec_wr_addr = '0;
    logic [DW-1:0] vec_wr_data = '0;
    logic          start = 1'b0;
    logic [RW-1:0] num_rows = '0;
    logic          done;
    logic          ptr_valid = 1'b0;
    logic          ptr_ready;
    logic [IW-1:0] ptr_data = '0;
    logic          el_valid = 1'b0;
    logic          el_ready;
    logic [DW-1:0] el_val = '0;
    logic [AW-1:0] el_col = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [PW-1:0] out_prod;
    logic [RW-1:0] out_row;
    logic          out_first;
    logic          out_last;

    always #2.5 clk = ~clk;

    csr_prod_stream u_dut (
        .clk(clk), .rst_n(rst_n),
        .vec_wr_en(vec_wr_en), .vec_wr_addr(vec_wr_addr), .vec_wr_data(vec_wr_data),
        .start(start), .num_rows(num_rows), .done(done),
        .ptr_valid(ptr_valid), .ptr_ready(ptr_ready), .ptr_data(ptr_data),
        .el_valid(el_valid), .el_ready(el_ready), .el_val(el_val), .el_col(el_col),
        .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod),
        .out_row(out_row), .out_first(out_first), .out_last(out_last)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model state
    logic [DW-1:0] vec_m [VD];
    int unsigned vals[$];
    int unsigned cols[$];
    int unsigned ptrs[$];
    logic [PW-1:0] q_prod[$];
    int            q_row[$];
    bit            q_first[$];
    bit            q_last[$];

    int  e_idx = 0, p_idx = 0;
    bit  run_on = 0, bp_en = 0;
    int  gap_pct = 0;
    bit  el_fire_q = 0, rp_fire_q = 0;
    bit  hold_prev = 0;
    logic [PW-1:0] h_prod; logic [RW-1:0] h_row; bit h_first, h_last;
    int  cyc = 0;
    int  fire_cyc = -1, out_cyc = -1;
    int  n_out = 0;
    bit  done_prev = 0;

    // Stimulus driver and per-clock comparison, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (el_fire_q) e_idx++;
            if (rp_fire_q) p_idx++;
            el_valid = run_on && (e_idx < vals.size()) && ($urandom_range(99) >= gap_pct);
            el_val   = el_valid ? vals[e_idx] : '0;
            el_col   = el_valid ? AW'(cols[e_idx]) : '0;
            ptr_valid = run_on && (p_idx < ptrs.size()) && ($urandom_range(99) >= gap_pct);
            ptr_data  = ptr_valid ? IW'(ptrs[p_idx]) : '0;
            out_ready = !bp_en || ($urandom_range(99) < 55);
            #1;
            el_fire_q = el_valid && el_ready;
            rp_fire_q = ptr_valid && ptr_ready;
            if (el_fire_q && fire_cyc < 0) fire_cyc = cyc;
            if (out_valid && out_cyc < 0) out_cyc = cyc;
            if (hold_prev) begin
                check(out_valid && out_prod == h_prod && out_row == h_row &&
                      out_first == h_first && out_last == h_last,
                      "R6", "hold under stall", {out_row, 31'd0, out_first, out_last}, {h_row, 31'd0, h_first, h_last});
            end
            if (out_valid && out_ready) begin
                if (q_prod.size() == 0) begin
                    check(0, "R3", "unexpected record", out_row, 64'hffff);
                end else begin
                    check(out_prod == q_prod[0], "R2", "product", out_prod, q_prod[0]);
                    check(int'(out_row) == q_row[0], "R3", "row tag", out_row, q_row[0]);
                    check(out_first == q_first[0] && out_last == q_last[0], "R4", "flags",
                          {out_first, out_last}, {q_first[0], q_last[0]});
                    if (q_prod[0] == 0 && q_first[0] && q_last[0])
                        check(out_prod == 0, "R5", "empty row zero", out_prod, 0);
                    void'(q_prod.pop_front()); void'(q_row.pop_front());
                    void'(q_first.pop_front()); void'(q_last.pop_front());
                    n_out++;
                end
            end
            if (done && !done_prev)
                check(q_prod.size() == 0 && !out_valid, "R8", "done after drain", q_prod.size(), 0);
            done_prev = done;
            hold_prev = out_valid && !out_ready;
            h_prod = out_prod; h_row = out_row; h_first = out_first; h_last = out_last;
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                check(0, "R8", "watchdog expired", cyc, 0);
                finish_up();
            end
        end
    end

    task automatic load_vec();
        foreach (cols[i]) begin
            @(negedge clk);
            vec_wr_en   = 1'b1;
            vec_wr_addr = AW'(cols[i]);
            vec_wr_data = $urandom_range(0, 65535);
            vec_m[cols[i]] = vec_wr_data;
        end
        @(negedge clk);
        vec_wr_en = 1'b0;
    endtask

    task automatic build_expect(input int rows);
        for (int r = 0; r < rows; r++) begin
            int unsigned s = ptrs[r];
            int unsigned e = ptrs[r+1];
            if (e <= s) begin
                q_prod.push_back('0); q_row.push_back(r);
                q_first.push_back(1); q_last.push_back(1);
            end else begin
                for (int unsigned i = s; i < e; i++) begin
                    int unsigned k = i - ptrs[0];
                    q_prod.push_back(PW'(vals[k]) * PW'(vec_m[cols[k]]));
                    q_row.push_back(r);
                    q_first.push_back(i == s);
                    q_last.push_back(i == e - 1);
                end
            end
        end
    endtask

    task automatic run(input int rows, input bit bp, input int gaps,
                       input bit restart_mid, input string tag);
        int expect_n;
        load_vec();
        build_expect(rows);
        expect_n = q_prod.size();
        @(negedge clk);
        e_idx = 0; p_idx = 0; n_out = 0;
        fire_cyc = -1; out_cyc = -1;
        bp_en = bp; gap_pct = gaps;
        num_rows = RW'(rows);
        start = 1'b1;
        run_on = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart_mid) begin
            repeat (6) @(negedge clk);
            start = 1'b1;   // R10: must be ignored mid-run
            @(negedge clk);
            start = 1'b0;
        end
        for (int w = 0; w < 5000 && !done; w++) @(negedge clk);
        #2;
        check(done == 1'b1, "R8", {tag, " done reached"}, done, 1);
        check(n_out == expect_n, "R3", {tag, " record count"}, n_out, expect_n);
        check(p_idx == ptrs.size() && e_idx == vals.size(), "R12", {tag, " inputs consumed"},
              {p_idx[31:0], e_idx[31:0]}, {ptrs.size(), vals.size()});
        if (restart_mid)
            check(n_out == expect_n && q_prod.size() == 0, "R10", "start ignored while busy", n_out, expect_n);
        run_on = 1'b0;
        bp_en = 0; gap_pct = 0;
        @(negedge clk);
    endtask

    task automatic random_matrix(input int rows, input int base);
        int unsigned p;
        vals.delete(); cols.delete(); ptrs.delete();
        p = base;
        ptrs.push_back(p);
        for (int r = 0; r < rows; r++) begin
            int len = $urandom_range(0, 4);
            for (int j = 0; j < len; j++) begin
                vals.push_back($urandom_range(0, 65535));
                cols.push_back($urandom_range(0, VD - 1));
            end
            p += len;
            ptrs.push_back(p);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!out_valid && !done && !el_ready && !ptr_ready, "R1", "in reset",
              {out_valid, done, el_ready, ptr_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !done && !el_ready && !ptr_ready, "R1", "after reset",
              {out_valid, done, el_ready, ptr_ready}, 0);

        // R2/R3/R9: worked 5x5 matrix, no stalls
        vals = '{1, 3, 2, 5, 4, 6, 4, 4, 2, 7, 8, 8, 5};
        cols = '{0, 1, 3, 0, 1, 2, 3, 4, 0, 2, 3, 1, 4};
        ptrs = '{0, 3, 5, 8, 11, 13};
        run(5, 0, 0, 0, "5x5");
        check(out_cyc - fire_cyc == 2, "R9", "latency", out_cyc - fire_cyc, 2);

        // R4/R6/R7: same matrix under backpressure and gaps, plus R10
        run(5, 1, 30, 1, "5x5 stalled");

        // R5: empty rows, including leading and trailing
        vals = '{9, 11, 13, 15, 17};
        cols = '{7, 8, 9, 10, 11};
        ptrs = '{0, 0, 2, 2, 2, 5, 5};
        run(6, 1, 20, 0, "empty rows");

        // R3: non-zero pointer origin
        vals = '{21, 22, 23, 24, 25};
        cols = '{100, 200, 300, 400, 500};
        ptrs = '{7, 9, 12};
        run(2, 0, 0, 0, "origin 7");

        // R11: zero rows
        vals.delete(); cols.delete();
        ptrs = '{4};
        run(0, 0, 0, 0, "zero rows");
        check(n_out == 0, "R11", "no records", n_out, 0);

        // Random matrices with stalls
        for (int t = 0; t < 4; t++) begin
            random_matrix($urandom_range(1, 10), $urandom_range(0, 20));
            run(ptrs.size() - 1, 1, 25, 0, "random");
        end

        finish_up();
    end

endmodule